// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps recently used linear-to-physical page translations for 4 KB pages so that an access which hits needs no walk through the two-level page tables. A requester gives a linear page number together with two flags: whether the access is a write and whether it runs at user privilege. One cycle later the block answers with a hit, the physical frame number and the stored permission bits. It also answers with a permission fault, or with a request for the external page walker to run.

The walker sends a finished translation back through the fill port. Software-visible maintenance takes two forms. The flush input empties the whole buffer in one cycle; it is asserted whenever the page-directory base register is reloaded. The single-page invalidate input removes the one entry that maps a given linear page, if that entry is present. The buffer holds 32 entries, arranged as 8 sets of 4 ways, which covers 128 KB of address space.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any page returns rsp_hit=0 and rsp_walk=1, and all response outputs are 0 while reset is held.
- R2: A lookup accepted in cycle N is answered in cycle N+1 with rsp_valid=1. The set index is page-number bits [2:0] (linear address bits 14:12) and the tag is page-number bits [19:3]. A hit returns the stored frame number and the stored user, writable and dirty bits.
- R3: A fill whose tag is already present in its set overwrites that same way. Otherwise the fill goes into the lowest-numbered invalid way of the set, and only when all four ways are valid does it replace the pseudo-LRU victim.
- R4: Each set keeps 3 tree bits, cleared at reset. The victim is way (b1 ? 1 : 0) when b0=0 and way (b2 ? 3 : 2) when b0=1. A fill into way w, or a lookup whose tag matches way w, sets b0=1 and b1=(w==0) when w<2, and sets b0=0 and b2=(w==2) when w>=2.
- R5: A lookup that matches an entry raises rsp_fault when it is a user access and the entry's user bit is 0, or when it is a write and the entry's writable bit is 0. In that case rsp_hit=1 and rsp_walk=0.
- R6: A write lookup that matches an entry whose dirty bit is 0, and that does not fault, is answered as a miss (rsp_hit=0, rsp_walk=1). The entry is left unchanged, so a later read still hits it.
- R7: A lookup that matches no valid entry returns rsp_hit=0, rsp_walk=1, rsp_fault=0 and a frame number of 0.
- R8: Asserting flush_all invalidates all 32 entries in a single cycle, and every lookup after that misses.
- R9: An invalidate clears only the entry whose set and tag match inv_vpn. All other entries stay valid, and an invalidate for a page that is not present has no effect.
- R10: Operations have a fixed priority: flush first, then invalidate, then fill, then lookup. An operation that loses in a cycle does nothing: a dropped fill writes nothing, and a dropped lookup gives rsp_valid=0 in the next cycle.
- R11: Whenever rsp_valid=0, or the answer is not a hit, rsp_pfn, rsp_usr, rsp_wr and rsp_dirty are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Linear page number for the lookup |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-privilege access |
| fill_valid | input | 1 | Load a translation from the walker |
| fill_vpn | input | 20 | Linear page number being filled |
| fill_pfn | input | 20 | Physical frame number being filled |
| fill_usr | input | 1 | Entry is accessible to user code |
| fill_wr | input | 1 | Entry is writable |
| fill_dirty | input | 1 | Entry is already marked dirty |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Linear page number to invalidate |
| flush_all | input | 1 | Invalidate every entry (page-directory base reload) |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation supplied |
| rsp_fault | output | 1 | Permission violation on a hit |
| rsp_walk | output | 1 | Page walk required |
| rsp_pfn | output | 20 | Physical frame number |
| rsp_usr | output | 1 | Stored user bit |
| rsp_wr | output | 1 | Stored writable bit |
| rsp_dirty | output | 1 | Stored dirty bit |

## Verification
Some rules are checked by assertions on every cycle. At most one way may match a probe. A flush must leave every valid bit clear, and an invalidated slot must be empty afterwards. The way just touched must never be the next victim, and a fill or invalidate must suppress the lookup answer. Hit, walk and fault must stay consistent, and outputs must be zero when no answer is present. Which way a fill overwrites, whether an eviction follows the tree order, and whether a walk is requested on a write to a clean page can only be shown by the bench's reference model. The model tracks contents and tree bits through directed eviction, permission, invalidate and priority-collision scenarios and through a long stretch of random mixed traffic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef struct packed {
    logic usr;
    logic wr;
    logic dirty;
  } tlb_attr_t;

  // victim chosen by the 3-bit tree
  function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] t);
    if (t[0]) plru_pick = t[2] ? 2'd3 : 2'd2;
    else      plru_pick = t[1] ? 2'd1 : 2'd0;
  endfunction

  // steer the tree away from the way just used
  function automatic logic [2:0] plru_mark(input logic [2:0] t, input logic [WAY_W-1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way import tlb_pkg::*; #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 17,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             we,
  input  logic [PFN_W-1:0] we_pfn,
  input  tlb_attr_t        we_attr,
  input  logic             clr,
  output logic             present,
  output logic             match,
  output logic [PFN_W-1:0] pfn_o,
  output tlb_attr_t        attr_o
);
  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tag_mem  [SETS];
  logic [PFN_W-1:0] pfn_mem  [SETS];
  tlb_attr_t        attr_mem [SETS];

  // valid bits need a one-cycle clear, so they live in flops
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
    end else begin
      if (clr) vld[idx] <= 1'b0;
      if (we)  vld[idx] <= 1'b1;
    end
  end

  // payload arrays: no reset, single write port
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[idx]  <= tag;
      pfn_mem[idx]  <= we_pfn;
      attr_mem[idx] <= we_attr;
    end
  end

  assign present = vld[idx];
  assign match   = vld[idx] && (tag_mem[idx] == tag);
  assign pfn_o   = pfn_mem[idx];
  assign attr_o  = attr_mem[idx];

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));

  a_r9_cleared_slot_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> !vld[$past(idx)]);

  a_r10_one_write_op: assert property (@(posedge clk) disable iff (rst)
    !(we && clr) && !(flush && (we || clr)));
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru import tlb_pkg::*; #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [2:0] tree [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree[s] <= '0;
    end else if (touch) begin
      tree[idx] <= plru_mark(tree[idx], touch_way);
    end
  end

  assign victim = plru_pick(tree[idx]);

  a_r4_recent_not_victim: assert property (@(posedge clk) disable iff (rst)
    touch |=> (plru_pick(tree[$past(idx)]) != $past(touch_way)));
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp import tlb_pkg::*; (
  input  logic      tag_hit,
  input  tlb_attr_t attr,
  input  logic      wr_req,
  input  logic      usr_req,
  output logic      hit,
  output logic      fault,
  output logic      walk
);
  logic need_dirty;

  always_comb begin
    fault      = tag_hit && ((usr_req && !attr.usr) || (wr_req && !attr.wr));
    need_dirty = tag_hit && !fault && wr_req && !attr.dirty;
    hit        = tag_hit && !need_dirty;
    walk       = !tag_hit || need_dirty;
  end

  always_comb begin
    a_r6_hit_walk_excl: assert (!(hit && walk));
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat import tlb_pkg::*; #(
  parameter int SETS  = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             lk_user,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_usr,
  input  logic             fill_wr,
  input  logic             fill_dirty,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             flush_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_walk,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_usr,
  output logic             rsp_wr,
  output logic             rsp_dirty
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic             do_inv, do_fill, do_look;
  logic [VPN_W-1:0] probe_vpn;
  logic [IDX_W-1:0] probe_idx;
  logic [TAG_W-1:0] probe_tag;

  logic [WAYS-1:0]  hit_vec, present_vec, we_vec, clr_vec;
  logic [PFN_W-1:0] way_pfn  [WAYS];
  tlb_attr_t        way_attr [WAYS];

  logic             hit_any;
  logic [WAY_W-1:0] hit_way, free_way, victim_way, fill_way, touch_way;
  logic             touch;
  logic [PFN_W-1:0] sel_pfn;
  tlb_attr_t        sel_attr, new_attr;
  logic             c_hit, c_fault, c_walk;

  // priority: flush > invalidate > fill > lookup
  assign do_inv  = !flush_all && inv_valid;
  assign do_fill = !flush_all && !inv_valid && fill_valid;
  assign do_look = !flush_all && !inv_valid && !fill_valid && lk_valid;

  // one shared probe port; the operations are exclusive
  always_comb begin
    if (do_inv)       probe_vpn = inv_vpn;
    else if (do_fill) probe_vpn = fill_vpn;
    else              probe_vpn = lk_vpn;
  end
  assign probe_idx = probe_vpn[IDX_W-1:0];
  assign probe_tag = probe_vpn[VPN_W-1:IDX_W];

  assign new_attr = '{usr: fill_usr, wr: fill_wr, dirty: fill_dirty};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign we_vec[w]  = do_fill && (fill_way == WAY_W'(w));
    assign clr_vec[w] = do_inv && hit_vec[w];

    tlb_way #(
      .SETS (SETS),
      .IDX_W(IDX_W),
      .TAG_W(TAG_W),
      .PFN_W(PFN_W)
    ) u_way (
      .clk    (clk),
      .rst    (rst),
      .flush  (flush_all),
      .idx    (probe_idx),
      .tag    (probe_tag),
      .we     (we_vec[w]),
      .we_pfn (fill_pfn),
      .we_attr(new_attr),
      .clr    (clr_vec[w]),
      .present(present_vec[w]),
      .match  (hit_vec[w]),
      .pfn_o  (way_pfn[w]),
      .attr_o (way_attr[w])
    );
  end

  assign hit_any = |hit_vec;

  always_comb begin
    sel_pfn  = '0;
    sel_attr = '0;
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        sel_pfn  = sel_pfn | way_pfn[w];
        sel_attr = tlb_attr_t'(sel_attr | way_attr[w]);
        hit_way  = WAY_W'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!present_vec[w]) free_way = WAY_W'(w);
    end
  end

  // re-fill of a present page reuses its way, then free ways, then victim
  always_comb begin
    if (hit_any)            fill_way = hit_way;
    else if (!(&present_vec)) fill_way = free_way;
    else                    fill_way = victim_way;
  end

  assign touch     = do_fill || (do_look && hit_any);
  assign touch_way = do_fill ? fill_way : hit_way;

  tlb_plru #(
    .SETS (SETS),
    .IDX_W(IDX_W)
  ) u_plru (
    .clk      (clk),
    .rst      (rst),
    .idx      (probe_idx),
    .touch    (touch),
    .touch_way(touch_way),
    .victim   (victim_way)
  );

  tlb_resp u_resp (
    .tag_hit(hit_any),
    .attr   (sel_attr),
    .wr_req (lk_write),
    .usr_req(lk_user),
    .hit    (c_hit),
    .fault  (c_fault),
    .walk   (c_walk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_walk  <= 1'b0;
      rsp_pfn   <= '0;
      rsp_usr   <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= do_look;
      rsp_hit   <= do_look && c_hit;
      rsp_fault <= do_look && c_fault;
      rsp_walk  <= do_look && c_walk;
      rsp_pfn   <= (do_look && c_hit) ? sel_pfn : '0;
      rsp_usr   <= do_look && c_hit && sel_attr.usr;
      rsp_wr    <= do_look && c_hit && sel_attr.wr;
      rsp_dirty <= do_look && c_hit && sel_attr.dirty;
    end
  end

  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  a_r10_fill_blocks_lookup: assert property (@(posedge clk) disable iff (rst)
    ((fill_valid || inv_valid || flush_all) |=> !rsp_valid));

  a_r5_fault_is_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_hit && !rsp_walk));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_pfn == '0 && !rsp_usr && !rsp_wr && !rsp_dirty && !rsp_fault));

  a_r6_write_hit_dirty: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && !rsp_fault && $past(lk_write)) |-> rsp_dirty);
endmodule

// File: tb/tlb_xlat_bench.sv
module tlb_xlat_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [19:0] lk_vpn = '0;
  logic        fill_valid = 0, fill_usr = 0, fill_wr = 0, fill_dirty = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        inv_valid = 0, flush_all = 0;
  logic [19:0] inv_vpn = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_walk, rsp_usr, rsp_wr, rsp_dirty;
  logic [19:0] rsp_pfn;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit        mv  [8][4];
  int        mtag[8][4];
  bit [19:0] mpfn[8][4];
  bit        mu  [8][4];
  bit        mw  [8][4];
  bit        md  [8][4];
  bit [2:0]  mt  [8];

  always #5 clk = ~clk;

  tlb_xlat u_tlb_xlat (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_usr(fill_usr), .fill_wr(fill_wr), .fill_dirty(fill_dirty),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_all(flush_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_walk(rsp_walk),
    .rsp_pfn(rsp_pfn), .rsp_usr(rsp_usr), .rsp_wr(rsp_wr), .rsp_dirty(rsp_dirty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int find_way(int s, int t);
    for (int w = 0; w < 4; w++) if (mv[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int tree_victim(bit [2:0] t);
    if (t[0] == 1'b0) return int'(t[1]);
    return 2 + int'(t[2]);
  endfunction

  function automatic bit [2:0] tree_use(bit [2:0] t, int w);
    bit [2:0] r;
    r = t;
    if (w < 2) begin r[0] = 1'b1; r[1] = (w == 0); end
    else       begin r[0] = 1'b0; r[2] = (w == 2); end
    return r;
  endfunction

  task automatic clear_in();
    lk_valid = 0; lk_write = 0; lk_user = 0; lk_vpn = '0;
    fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_usr = 0; fill_wr = 0; fill_dirty = 0;
    inv_valid = 0; inv_vpn = '0; flush_all = 0;
  endtask

  // one clock: predict, advance, compare every output
  task automatic step();
    bit f, iv, fl, lk, flt;
    bit ev, eh, ef, ewk, eu, ew, ed;
    bit [19:0] ep;
    int s, t, w;
    f  = flush_all;
    iv = !f && inv_valid;
    fl = !f && !iv && fill_valid;
    lk = !f && !iv && !fl && lk_valid;
    ev = lk; eh = 0; ef = 0; ewk = 0; eu = 0; ew = 0; ed = 0; ep = '0;
    if (lk) begin
      s = int'(lk_vpn[2:0]); t = int'(lk_vpn[19:3]);
      w = find_way(s, t);
      if (w < 0) ewk = 1;
      else begin
        flt = (lk_user && !mu[s][w]) || (lk_write && !mw[s][w]);
        if (!flt && lk_write && !md[s][w]) ewk = 1;
        else begin
          eh = 1; ef = flt; ep = mpfn[s][w];
          eu = mu[s][w]; ew = mw[s][w]; ed = md[s][w];
        end
        mt[s] = tree_use(mt[s], w);
      end
    end
    if (f) foreach (mv[a, b]) mv[a][b] = 0;
    if (iv) begin
      s = int'(inv_vpn[2:0]); t = int'(inv_vpn[19:3]);
      w = find_way(s, t);
      if (w >= 0) mv[s][w] = 0;
    end
    if (fl) begin
      s = int'(fill_vpn[2:0]); t = int'(fill_vpn[19:3]);
      w = find_way(s, t);
      if (w < 0) begin
        for (int k = 3; k >= 0; k--) if (!mv[s][k]) w = k;
        if (w < 0) w = tree_victim(mt[s]);
      end
      mv[s][w] = 1; mtag[s][w] = t; mpfn[s][w] = fill_pfn;
      mu[s][w] = fill_usr; mw[s][w] = fill_wr; md[s][w] = fill_dirty;
      mt[s] = tree_use(mt[s], w);
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == ev, "R10 rsp_valid", int'(rsp_valid), int'(ev));
    chk(rsp_hit == eh, "R2 rsp_hit", int'(rsp_hit), int'(eh));
    chk(rsp_fault == ef, "R5 rsp_fault", int'(rsp_fault), int'(ef));
    chk(rsp_walk == ewk, "R7 rsp_walk", int'(rsp_walk), int'(ewk));
    chk(rsp_pfn == ep, "R2 rsp_pfn", int'(rsp_pfn), int'(ep));
    chk({rsp_usr, rsp_wr, rsp_dirty} == {eu, ew, ed}, "R11 attrs",
        int'({rsp_usr, rsp_wr, rsp_dirty}), int'({eu, ew, ed}));
  endtask

  task automatic look(input logic [19:0] v, input bit wr, input bit us);
    clear_in(); lk_valid = 1; lk_vpn = v; lk_write = wr; lk_user = us;
    step();
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit u, input bit wr, input bit d);
    clear_in(); fill_valid = 1; fill_vpn = v; fill_pfn = p;
    fill_usr = u; fill_wr = wr; fill_dirty = d;
    step();
  endtask

  task automatic inval(input logic [19:0] v);
    clear_in(); inv_valid = 1; inv_vpn = v;
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (mt[s]) mt[s] = '0;
    foreach (mv[a, b]) mv[a][b] = 0;
    clear_in();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rsp_hit && !rsp_walk && rsp_pfn == '0, "R1 reset outputs",
        int'({rsp_valid, rsp_hit, rsp_walk}), 0);
    rst = 0;

    // R1/R7: empty buffer misses
    look(20'h00010, 0, 0);
    chk(rsp_walk && !rsp_hit, "R1 first lookup misses", int'(rsp_walk), 1);
    chk(rsp_pfn == '0, "R7 miss frame zero", int'(rsp_pfn), 0);

    // R2: basic hit
    fill(20'h00010, 20'hABCDE, 1, 1, 1);
    look(20'h00010, 0, 1);
    chk(rsp_hit == 1, "R2 hit after fill", int'(rsp_hit), 1);
    chk(rsp_pfn == 20'hABCDE, "R2 frame returned", int'(rsp_pfn), 'hABCDE);

    // R5: permission faults on supervisor read-only page
    fill(20'h00021, 20'h12345, 0, 0, 0);
    look(20'h00021, 0, 1);
    chk(rsp_fault && rsp_hit, "R5 user on supervisor page", int'(rsp_fault), 1);
    look(20'h00021, 1, 0);
    chk(rsp_fault && !rsp_walk, "R5 write to read-only", int'(rsp_fault), 1);
    look(20'h00021, 0, 0);
    chk(rsp_hit && !rsp_fault, "R5 supervisor read allowed", int'(rsp_fault), 0);

    // R6: write to clean page asks for a walk
    fill(20'h00032, 20'h0F0F0, 1, 1, 0);
    look(20'h00032, 1, 1);
    chk(rsp_walk && !rsp_hit, "R6 clean write walks", int'(rsp_walk), 1);
    look(20'h00032, 0, 1);
    chk(rsp_hit && rsp_pfn == 20'h0F0F0, "R6 entry kept", int'(rsp_pfn), 'h0F0F0);

    // R3/R4: fill set 3 beyond capacity
    for (int k = 1; k <= 4; k++) fill(20'((k << 3) | 3), 20'(32'h100 + k), 1, 1, 1);
    fill(20'((5 << 3) | 3), 20'h00105, 1, 1, 1);
    look(20'((1 << 3) | 3), 0, 0);
    chk(rsp_walk, "R4 oldest way evicted", int'(rsp_walk), 1);
    look(20'((2 << 3) | 3), 0, 0);
    chk(rsp_hit && rsp_pfn == 20'h00102, "R3 other way kept", int'(rsp_pfn), 'h102);
    fill(20'((3 << 3) | 3), 20'h00333, 1, 1, 1);
    look(20'((3 << 3) | 3), 0, 0);
    chk(rsp_pfn == 20'h00333, "R3 refill overwrites in place", int'(rsp_pfn), 'h333);
    look(20'((4 << 3) | 3), 0, 0);
    chk(rsp_hit, "R3 neighbour survives refill", int'(rsp_hit), 1);
    look(20'((5 << 3) | 3), 0, 0);
    chk(rsp_hit, "R3 newest survives refill", int'(rsp_hit), 1);

    // R9: single-page invalidate
    inval(20'((4 << 3) | 3));
    look(20'((4 << 3) | 3), 0, 0);
    chk(rsp_walk, "R9 invalidated page misses", int'(rsp_walk), 1);
    look(20'((5 << 3) | 3), 0, 0);
    chk(rsp_hit, "R9 other page still hits", int'(rsp_hit), 1);
    inval(20'h7FFF3);
    look(20'((5 << 3) | 3), 0, 0);
    chk(rsp_hit, "R9 absent invalidate no effect", int'(rsp_hit), 1);

    // R10: priority collisions
    clear_in(); fill_valid = 1; fill_vpn = 20'h00044; fill_pfn = 20'h44444;
    fill_usr = 1; fill_wr = 1; fill_dirty = 1; lk_valid = 1; lk_vpn = 20'h00010;
    step();
    chk(!rsp_valid, "R10 lookup dropped by fill", int'(rsp_valid), 0);
    chk(rsp_pfn == '0, "R11 no answer zero frame", int'(rsp_pfn), 0);
    look(20'h00044, 0, 0);
    chk(rsp_hit && rsp_pfn == 20'h44444, "R10 fill won", int'(rsp_pfn), 'h44444);
    clear_in(); inv_valid = 1; inv_vpn = 20'h00044;
    fill_valid = 1; fill_vpn = 20'h00066; fill_pfn = 20'h66666; fill_wr = 1;
    step();
    look(20'h00066, 0, 0);
    chk(rsp_walk, "R10 fill dropped by invalidate", int'(rsp_walk), 1);
    look(20'h00044, 0, 0);
    chk(rsp_walk, "R9 invalidate won", int'(rsp_walk), 1);
    clear_in(); flush_all = 1;
    fill_valid = 1; fill_vpn = 20'h00055; fill_pfn = 20'h55555;
    step();
    look(20'h00055, 0, 0);
    chk(rsp_walk, "R10 fill dropped by flush", int'(rsp_walk), 1);
    look(20'h00010, 0, 0);
    chk(rsp_walk, "R8 flushed entry misses", int'(rsp_walk), 1);
    look(20'h00032, 0, 0);
    chk(rsp_walk, "R8 second flushed entry misses", int'(rsp_walk), 1);

    // mixed random traffic with collisions
    for (int i = 0; i < 3000; i++) begin
      clear_in();
      flush_all  = ($urandom % 60) == 0;
      inv_valid  = ($urandom % 10) == 0;
      inv_vpn    = 20'((($urandom % 6) << 3) | ($urandom % 8));
      fill_valid = ($urandom % 3) == 0;
      fill_vpn   = 20'((($urandom % 6) << 3) | ($urandom % 8));
      fill_pfn   = 20'($urandom);
      fill_usr   = 1'($urandom); fill_wr = 1'($urandom); fill_dirty = 1'($urandom);
      lk_valid   = ($urandom % 10) < 7;
      lk_vpn     = 20'((($urandom % 6) << 3) | ($urandom % 8));
      lk_write   = 1'($urandom); lk_user = 1'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule